// File: doc/BRIEF.md
# Line Window and Border Mask Generator

This block produces the control strobes for one television scan line. Each clock edge is one tick of 0.5 µs, and a line is 128 ticks long. A line start pulse begins a line. The block then counts through the line and drives six outputs from that count:

- horizontal sync, active low
- a picture-inhibit flag
- a busy window, active low
- a data-fetch window, active low
- a horizontal mask
- a line-end strobe that a frame sequencer uses to start the next line

Two kinds of line exist. A blank line carries only sync and the inhibit window. A data line also opens a busy window. Inside the busy window it opens a fetch window, and inside the fetch window it raises a mask that marks the unmasked picture span. A wide mode makes the unmasked span longer, which covers the ragged edges that horizontal scrolling leaves. The line kind and the mode are captured with the start pulse. Tick numbers below count from 0, which is the first cycle after the edge that accepted the start.

Top module: `hline_gen`

## Requirements
- R1: After reset, and whenever no line is running, the outputs rest at sync_n=1, inhibit=1, busy_n=1, fetch_n=1, mask=0, line_end=0.
- R2: A line_start seen while no line runs starts a line, and the line lasts exactly 128 ticks (0..127). A line_start seen during ticks 0..126 is ignored.
- R3: sync_n is low on ticks 0..8 and high on all other ticks.
- R4: inhibit is high on ticks 0..24 and low on ticks 25..127.
- R5: On a blank line (line_type=0), busy_n and fetch_n stay high and mask stays low for the whole line.
- R6: On a data line (line_type=1), busy_n is low on ticks 35..105.
- R7: On a data line, fetch_n is low on ticks 36..105.
- R8: On a data line in narrow mode (wide_mode=0), mask is high on ticks 41..99, which is 59 ticks.
- R9: On a data line in wide mode (wide_mode=1), mask is high on ticks 40..101, which is 62 ticks.
- R10: line_type and wide_mode are sampled only with an accepted line_start. Changing them during a line has no effect on that line.
- R11: line_end is high on tick 127 only.
- R12: A line_start on tick 127 is accepted, and the next tick is tick 0 of a new line, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one edge per 0.5 µs |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Request to begin a line |
| line_type | input | 1 | 1 = data line, 0 = blank line |
| wide_mode | input | 1 | 1 = wide unmasked span, 0 = narrow |
| sync_n | output | 1 | Horizontal sync, active low |
| inhibit | output | 1 | High outside the picture window |
| busy_n | output | 1 | Busy window, active low |
| fetch_n | output | 1 | Data-fetch window, active low |
| mask | output | 1 | High across the unmasked span |
| line_end | output | 1 | One-tick pulse on the last tick of a line |

## Verification
The assertions assume that every input is synchronous to the tick clock and settled at the edge. They make no assumption about when line_start arrives. Their window nesting must therefore hold for any start pattern, including pulses in the middle of a line and back-to-back lines.

The stimulus changes inputs only on the falling edge. It places start pulses on the last tick, after idle gaps, and at random points inside a line. It also toggles the line kind and the mode in the middle of a line.

// File: rtl/hline_pkg.sv
package hline_pkg;
  localparam int LINE_TICKS    = 128;
  localparam int SYNC_TICKS    = 9;
  localparam int PORCH_TICKS   = 16;
  localparam int LEFT_TICKS    = 10;
  localparam int FETCH_TICKS   = 70;
  localparam int NARROW_LEAD   = 5;
  localparam int NARROW_SPAN   = 59;
  localparam int WIDE_LEAD     = 4;
  localparam int WIDE_SPAN     = 62;

  typedef struct packed {
    logic data_line;
    logic wide;
  } line_cfg_t;
endpackage

// File: rtl/hline_counter.sv
module hline_counter #(
  parameter int LINE_T = 128,
  localparam int CW = $clog2(LINE_T)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  hline_pkg::line_cfg_t cfg_in,
  output logic                 active,
  output logic [CW-1:0]        cnt,
  output hline_pkg::line_cfg_t cfg_q
);
  localparam logic [CW-1:0] LAST = CW'(LINE_T - 1);

  logic at_last;
  logic accept;

  assign at_last = active && (cnt == LAST);
  assign accept  = line_start && (!active || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
      cfg_q  <= cfg_in;
    end else if (active) begin
      if (at_last) active <= 1'b0;
      else         cnt    <= cnt + 1'b1;
    end
  end

  AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_last) |=> (active && cnt == $past(cnt) + 1'b1)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_last) |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/hline_window.sv
module hline_window #(
  parameter int CW    = 7,
  parameter int START = 0,
  parameter int LEN   = 1
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW:0] LO = (CW+1)'(START);
  localparam logic [CW:0] HI = (CW+1)'(START + LEN);

  assign hit = active && ({1'b0, cnt} >= LO) && ({1'b0, cnt} < HI);
endmodule

// File: rtl/hline_gen.sv
module hline_gen #(
  parameter int LINE_T      = hline_pkg::LINE_TICKS,
  parameter int SYNC_T      = hline_pkg::SYNC_TICKS,
  parameter int PORCH_T     = hline_pkg::PORCH_TICKS,
  parameter int LEFT_T      = hline_pkg::LEFT_TICKS,
  parameter int FETCH_T     = hline_pkg::FETCH_TICKS,
  parameter int NARROW_LEAD = hline_pkg::NARROW_LEAD,
  parameter int NARROW_SPAN = hline_pkg::NARROW_SPAN,
  parameter int WIDE_LEAD   = hline_pkg::WIDE_LEAD,
  parameter int WIDE_SPAN   = hline_pkg::WIDE_SPAN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic line_type,
  input  logic wide_mode,
  output logic sync_n,
  output logic inhibit,
  output logic busy_n,
  output logic fetch_n,
  output logic mask,
  output logic line_end
);
  localparam int CW          = $clog2(LINE_T);
  localparam int WINDOW_ON   = SYNC_T + PORCH_T;
  localparam int BUSY_ON     = WINDOW_ON + LEFT_T;
  localparam int FETCH_ON    = BUSY_ON + 1;
  localparam int BUSY_T      = FETCH_T + 1;

  hline_pkg::line_cfg_t cfg_in, cfg_q;
  logic          active;
  logic [CW-1:0] cnt;
  logic          sync_hit, pic_hit, busy_hit, fetch_hit, end_hit;
  logic [1:0]    mask_hit;

  assign cfg_in.data_line = line_type;
  assign cfg_in.wide      = wide_mode;

  hline_counter #(.LINE_T(LINE_T)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .cfg_in(cfg_in),
    .active(active), .cnt(cnt), .cfg_q(cfg_q)
  );

  hline_window #(.CW(CW), .START(0), .LEN(SYNC_T)) u_sync (
    .active(active), .cnt(cnt), .hit(sync_hit));
  hline_window #(.CW(CW), .START(WINDOW_ON), .LEN(LINE_T - WINDOW_ON)) u_pic (
    .active(active), .cnt(cnt), .hit(pic_hit));
  hline_window #(.CW(CW), .START(BUSY_ON), .LEN(BUSY_T)) u_busy (
    .active(active), .cnt(cnt), .hit(busy_hit));
  hline_window #(.CW(CW), .START(FETCH_ON), .LEN(FETCH_T)) u_fetch (
    .active(active), .cnt(cnt), .hit(fetch_hit));
  hline_window #(.CW(CW), .START(LINE_T - 1), .LEN(1)) u_end (
    .active(active), .cnt(cnt), .hit(end_hit));

  for (genvar m = 0; m < 2; m++) begin : g_mask
    localparam int LEAD = (m == 1) ? WIDE_LEAD : NARROW_LEAD;
    localparam int SPAN = (m == 1) ? WIDE_SPAN : NARROW_SPAN;
    hline_window #(.CW(CW), .START(FETCH_ON + LEAD), .LEN(SPAN)) u_m (
      .active(active), .cnt(cnt), .hit(mask_hit[m]));
  end

  assign sync_n   = ~sync_hit;
  assign inhibit  = ~pic_hit;
  assign busy_n   = ~(cfg_q.data_line & busy_hit);
  assign fetch_n  = ~(cfg_q.data_line & fetch_hit);
  assign mask     = cfg_q.data_line & mask_hit[cfg_q.wide];
  assign line_end = end_hit;

  AST_SYNC_OUTSIDE_PICTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> inhibit); // R3
  AST_BUSY_INSIDE_PICTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !inhibit); // R6
  AST_FETCH_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_n |-> !busy_n); // R7
  AST_MASK_INSIDE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !fetch_n); // R8
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfg_q.data_line) |-> (busy_n && fetch_n && !mask)); // R5
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !line_end); // R11
endmodule

// File: tb/hline_gen_tb_top.sv
module hline_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, line_type = 1'b0, wide_mode = 1'b0;
  logic sync_n, inhibit, busy_n, fetch_n, mask, line_end;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  string ctx = "R1";

  bit m_act = 1'b0, m_type = 1'b0, m_wide = 1'b0;
  int m_tick = 0;

  always #5 clk = ~clk;

  hline_gen dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_type(line_type),
    .wide_mode(wide_mode), .sync_n(sync_n), .inhibit(inhibit), .busy_n(busy_n),
    .fetch_n(fetch_n), .mask(mask), .line_end(line_end)
  );

  // order: sync_n, inhibit, busy_n, fetch_n, mask, line_end
  function automatic logic [5:0] expect_out(bit act, int t, bit dl, bit wd);
    logic [5:0] e;
    if (!act) return 6'b111100;                       // R1
    e[5] = !(t <= 8);                                 // R3
    e[4] = (t <= 24);                                 // R4
    e[3] = !(dl && t >= 35 && t <= 105);              // R6, R5
    e[2] = !(dl && t >= 36 && t <= 105);              // R7, R5
    e[1] = dl && (wd ? (t >= 40 && t <= 101)          // R9
                     : (t >= 41 && t <= 99));         // R8
    e[0] = (t == 127);                                // R11
    return e;
  endfunction

  function automatic string tag_of(int idx);
    if (!m_act) return "R1";
    case (idx)
      5: return "R3";
      4: return "R4";
      3: return m_type ? "R6" : "R5";
      2: return m_type ? "R7" : "R5";
      1: return !m_type ? "R5" : (m_wide ? "R9" : "R8");
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all();
    logic [5:0] got, exp;
    got = {sync_n, inhibit, busy_n, fetch_n, mask, line_end};
    exp = expect_out(m_act, m_tick, m_type, m_wide);
    for (int i = 5; i >= 0; i--) begin
      n_chk++;
      if (got[i] !== exp[i]) begin
        n_fail++;
        $display("FAIL %s [%s] out%0d tick %0d: got %b exp %b",
                 tag_of(i), ctx, i, m_tick, got[i], exp[i]);
      end
    end
  endtask

  // called on a falling edge; drives, waits one tick, checks on next fall
  task automatic step(bit ls, bit lt, bit wm);
    line_start = ls; line_type = lt; wide_mode = wm;
    @(posedge clk);
    if (ls && (!m_act || m_tick == 127)) begin       // R2, R12
      m_act = 1'b1; m_tick = 0; m_type = lt; m_wide = wm;
    end else if (m_act) begin
      if (m_tick == 127) m_act = 1'b0;
      else m_tick++;
    end
    @(negedge clk);
    compare_all();
  endtask

  // one full line; start on entry, random noise on the control pins after
  task automatic run_line(bit lt, bit wm, bit noisy);
    step(1'b1, lt, wm);
    while (m_tick < 127) begin
      if (noisy) step(($urandom_range(0, 15) == 0), 1'($urandom), 1'($urandom));
      else       step(1'b0, lt, wm);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    ctx = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    step(1'b0, 1'b1, 1'b1);                          // R1 idle stays quiet

    ctx = "R8"; run_line(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    ctx = "R9"; run_line(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    ctx = "R5"; run_line(1'b0, 1'b1, 1'b0);
    // R12: back-to-back start on tick 127
    ctx = "R12"; run_line(1'b1, 1'b0, 1'b0);
    run_line(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    // R10 and R2: pins toggle and stray starts inside a line
    ctx = "R10"; run_line(1'b1, 1'b0, 1'b1);
    ctx = "R2";  run_line(1'b0, 1'b0, 1'b1);

    ctx = "RND";
    for (int k = 0; k < 30; k++) begin
      run_line(1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) == 0) begin
        int gap = $urandom_range(1, 4);
        for (int g = 0; g < gap; g++) step(1'b0, 1'($urandom), 1'($urandom));
      end
    end
    step(1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule